// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block collects 96 level-sensitive interrupt sources into two processor lines: a normal line (`irq_o`) and a fast line (`fiq_o`). Every source owns one bit in each of several 32-bit register banks, with three words per bank. A pending bit latches whenever its source is high and stays set until software clears it by writing a one to that bit. A mask bit suppresses a source on both lines. A select bit moves a source onto the fast line as well. A read-only vector register holds the byte offset (source number times four) of the lowest-numbered source that is pending and unmasked. Software can use this value to index a handler table directly.

Software reaches the block over a simple synchronous bus with one request strobe and a write flag. Writes take effect at the clock edge that samples the request. Read data returns one cycle later, under a response-valid flag. A two-state machine drives the read path. `BUS_IDLE` means no response is outstanding. A read request moves it to `BUS_RESP` (transition *read accepted*). While in `BUS_RESP`, a back-to-back read keeps it there (transition *read streamed*). Any cycle without a read returns it to `BUS_IDLE` (transition *response done*). Writes never change the state.

The register window is 1 KB, at 10 address bits. Two things are plain storage: a fast-pending bank and an enable bank. Three more words are also plain storage, labelled base, protect and NMI.

Top module: `irq_route_ctrl`

Register map (byte offsets, word aligned; the word within a bank is chosen by address bits [3:2]):

| Offset | Register |
|---|---|
| 0x00 | vector (read only) |
| 0x04 | base (bits [1:0] read as zero) |
| 0x08 | protect word |
| 0x0C | NMI word |
| 0x10, 0x14, 0x18 | normal pending, words 0..2 (write one to clear) |
| 0x20, 0x24, 0x28 | fast pending storage, words 0..2 (write one to clear) |
| 0x30, 0x34, 0x38 | select, words 0..2 |
| 0x40, 0x44, 0x48 | enable storage, words 0..2 |
| 0x50, 0x54, 0x58 | mask, words 0..2 (1 = masked) |

Source n sits in word n/32, bit n%32 of each bank.

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low and every register reads zero, including vector, base, protect, NMI and all bank words.
- R2: A source that is high at a clock edge sets its pending bit. The bit stays set after the source falls, and no pending bit becomes set without its source being high.
- R3: Writing a pending word clears exactly the bits written as one and leaves bits written as zero unchanged. If a source is high in the same cycle that its bit is cleared, the bit stays set.
- R4: `irq_o` is high exactly when some source has its pending bit set and its mask bit clear. It changes in the cycle after the register change, with no further delay.
- R5: `fiq_o` is high exactly when some source is pending, unmasked and has its select bit set.
- R6: The vector register reads (w*32+b)*4 for the lowest-numbered pending, unmasked source, where w is the word and b is the bit. It reads zero when there is none, so source 0 and "none" both read zero and are told apart by `irq_o`.
- R7: In every bank, offsets base+0, base+4 and base+8 select words 0, 1 and 2 through address bits [3:2].
- R8: A write to the base word stores the data with bits [1:0] forced to zero. The protect and NMI words store and return the full written data.
- R9: The enable bank and the fast-pending bank can be read and written, and the fast-pending bank is write-one-to-clear. Neither bank affects `irq_o`, `fiq_o` or the vector.
- R10: Reads of unmapped offsets return zero. Unmapped offsets include offset 0x1C (word 3 of a bank), any offset from 0x5C upward, and any offset with bits [1:0] non-zero. Writes to unmapped offsets and to the vector offset change nothing.
- R11: `rsp_valid_o` is high in the cycle after a read request and low in the cycle after a cycle with no read request. `rsp_rdata_o` carries the register contents as they were at the requesting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Interrupt source levels, one bit per source |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 10 | Byte offset into the 1 KB window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The find-first scan is tried against sources that differ in word and bit position:
- A lone source in word 1 checks the word-times-32 term of the vector.
- Adding a lower source in word 0 checks that priority goes by number rather than arrival order.
- Masking and unmasking walks the winner up to word 2, then shows the vector falling to zero when nothing is active.

Source 0 is driven on its own to show a zero vector alongside a high `irq_o`.

Select bits are set on a masked source and then on an unmasked one, so the fast line's dependence on the mask can be seen.

Clear writes are issued with zero data, with the source idle, and in the same cycle as a held source. Together these separate write-one-to-clear from plain overwrite, and show which wins when a set and a clear collide.

// File: rtl/irc_pkg.sv
package irc_pkg;

    // Bank identifiers, decoded from address bits above [3:0]
    localparam int BANK_SCALAR = 0;
    localparam int BANK_IRQP   = 1;
    localparam int BANK_FIQP   = 2;
    localparam int BANK_SEL    = 3;
    localparam int BANK_EN     = 4;
    localparam int BANK_MASK   = 5;

    // Word index inside the scalar group
    localparam int SCL_VECTOR  = 0;
    localparam int SCL_BASE    = 1;
    localparam int SCL_PROTECT = 2;
    localparam int SCL_NMI     = 3;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irc_prio_scan.sv
module irc_prio_scan #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    localparam int NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int VEC_W    = SRC_W + 2
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic               hit_o,
    output logic [VEC_W-1:0]   vec_o
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [NUM_WORDS-1:0]            w_any;
    logic [NUM_WORDS-1:0][BIT_W-1:0] w_idx;
    logic [SRC_W-1:0]                src_num;

    // Per-word find-first: scan high to low so the lowest set bit wins
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [BIT_W-1:0] idx_g;
        always_comb begin
            idx_g = '0;
            for (int b = WORD_W - 1; b >= 0; b--) begin
                if (act_i[w*WORD_W + b]) idx_g = BIT_W'(b);
            end
        end
        assign w_any[w] = |act_i[w*WORD_W +: WORD_W];
        assign w_idx[w] = idx_g;
    end

    // Word-level select: lowest word with any active bit wins
    always_comb begin
        hit_o   = 1'b0;
        src_num = '0;
        for (int w = NUM_WORDS - 1; w >= 0; w--) begin
            if (w_any[w]) begin
                hit_o   = 1'b1;
                src_num = SRC_W'(w * WORD_W) + SRC_W'(w_idx[w]);
            end
        end
    end

    assign vec_o = {src_num, 2'b00};

endmodule

// File: rtl/irc_regfile.sv
module irc_regfile
    import irc_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 10,
    localparam int NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int VEC_W    = $clog2(NUM_SRC) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    input  logic [VEC_W-1:0]   vec_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] sel_o
);
    localparam int BANK_W = ADDR_W - 4;

    logic [NUM_WORDS-1:0][WORD_W-1:0] pend_q, fpend_q, sel_q, en_q, mask_q;
    logic [WORD_W-1:0] base_q, prot_q, nmi_q;
    logic [NUM_SRC-1:0] clr_flat;

    logic              aligned;
    logic [1:0]        widx;
    logic [BANK_W-1:0] bank;
    logic              wr_ok;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign widx    = addr_i[3:2];
    assign bank    = addr_i[ADDR_W-1:4];
    assign wr_ok   = wr_en_i && aligned;

    // Scalar words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            prot_q <= '0;
            nmi_q  <= '0;
        end else if (wr_ok && int'(bank) == BANK_SCALAR) begin
            case (int'(widx))
                SCL_BASE:    base_q <= {wdata_i[WORD_W-1:2], 2'b00};
                SCL_PROTECT: prot_q <= wdata_i;
                SCL_NMI:     nmi_q  <= wdata_i;
                default:     ;
            endcase
        end
    end

    // Banked words
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
        logic             wsel;
        logic [WORD_W-1:0] clr_w, fclr_w;

        assign wsel   = wr_ok && (int'(widx) == w);
        assign clr_w  = (wsel && int'(bank) == BANK_IRQP) ? wdata_i : '0;
        assign fclr_w = (wsel && int'(bank) == BANK_FIQP) ? wdata_i : '0;
        assign clr_flat[w*WORD_W +: WORD_W] = clr_w;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[w]  <= '0;
                fpend_q[w] <= '0;
                sel_q[w]   <= '0;
                en_q[w]    <= '0;
                mask_q[w]  <= '0;
            end else begin
                // a live source overrides a same-cycle clear
                pend_q[w]  <= (pend_q[w] & ~clr_w) | src_i[w*WORD_W +: WORD_W];
                fpend_q[w] <= fpend_q[w] & ~fclr_w;
                if (wsel && int'(bank) == BANK_SEL)  sel_q[w]  <= wdata_i;
                if (wsel && int'(bank) == BANK_EN)   en_q[w]   <= wdata_i;
                if (wsel && int'(bank) == BANK_MASK) mask_q[w] <= wdata_i;
            end
        end

        assign pend_o[w*WORD_W +: WORD_W] = pend_q[w];
        assign mask_o[w*WORD_W +: WORD_W] = mask_q[w];
        assign sel_o[w*WORD_W +: WORD_W]  = sel_q[w];
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (int'(bank) == BANK_SCALAR) begin
                case (int'(widx))
                    SCL_VECTOR:  rdata_o = WORD_W'(vec_i);
                    SCL_BASE:    rdata_o = base_q;
                    SCL_PROTECT: rdata_o = prot_q;
                    default:     rdata_o = nmi_q;
                endcase
            end else begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (int'(widx) == w) begin
                        case (int'(bank))
                            BANK_IRQP: rdata_o = pend_q[w];
                            BANK_FIQP: rdata_o = fpend_q[w];
                            BANK_SEL:  rdata_o = sel_q[w];
                            BANK_EN:   rdata_o = en_q[w];
                            BANK_MASK: rdata_o = mask_q[w];
                            default:   rdata_o = '0;
                        endcase
                    end
                end
            end
        end
    end

    // Every source high at an edge is pending afterwards
    assert_pend_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(src_i)) == $past(src_i)));

    // No pending bit appears without its source
    assert_pend_no_spont_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(src_i)) == '0));

    // Only bits named in a clear write can drop
    assert_pend_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_o) & ~$past(clr_flat) & ~pend_o) == '0));

endmodule

// File: rtl/irc_bus_fsm.sv
module irc_bus_fsm
    import irc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              wr_en_o,
    output logic              rsp_valid_o,
    output logic [WORD_W-1:0] rsp_rdata_o
);
    bus_state_e state_q, state_d;
    logic       rd_req;

    assign rd_req  = req_valid_i && !req_write_i;
    assign wr_en_o = req_valid_i && req_write_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: read accepted, read streamed, response done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
            default:               state_d = BUS_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata_o <= '0;
        else if (rd_req) rsp_rdata_o <= rdata_i;
    end
    assign rsp_valid_o = (state_q == BUS_RESP);

    assert_rsp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);

    assert_rsp_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && !req_write_i));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 10,
    localparam int NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int VEC_W    = $clog2(NUM_SRC) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [WORD_W-1:0]  req_wdata_i,
    output logic               rsp_valid_o,
    output logic [WORD_W-1:0]  rsp_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    logic               wr_en;
    logic [WORD_W-1:0]  rdata;
    logic [NUM_SRC-1:0] pend, mask, sel, active;
    logic [VEC_W-1:0]   vec;
    logic               hit;

    irc_bus_fsm #(.WORD_W(WORD_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .rdata_i(rdata), .wr_en_o(wr_en),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
    );

    irc_regfile #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .wr_en_i(wr_en), .addr_i(req_addr_i), .wdata_i(req_wdata_i),
        .vec_i(vec), .rdata_o(rdata),
        .pend_o(pend), .mask_o(mask), .sel_o(sel)
    );

    assign active = pend & ~mask;

    irc_prio_scan #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_scan (
        .act_i(active), .hit_o(hit), .vec_o(vec)
    );

    assign irq_o = hit;
    assign fiq_o = |(active & sel);

    assert_fiq_needs_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    assert_vec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec == '0));

    assert_vec_points_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend[vec[VEC_W-1:2]] && !mask[vec[VEC_W-1:2]]));

endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq, fiq;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irq_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Driver: writes
    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Driver: reads push the expected item into the scoreboard
    task automatic bus_read(input logic [9:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_src(input int n, input int cycles);
        @(negedge clk);
        src[n] = 1'b1;
        repeat (cycles) @(negedge clk);
        src[n] = 1'b0;
    endtask

    // Monitor: pop and compare responses
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 fiq", 32'(fiq), 0);
        bus_read(10'h000, 0, "R1 vector");
        bus_read(10'h004, 0, "R1 base");
        bus_read(10'h00C, 0, "R1 nmi");
        bus_read(10'h018, 0, "R1 pend w2");
        bus_read(10'h050, 0, "R1 mask w0");

        // R11 response timing
        bus_read(10'h008, 0, "R11 protect data");
        check("R11 valid after read", 32'(rsp_valid), 1);
        @(negedge clk);
        check("R11 valid drops", 32'(rsp_valid), 0);

        // R2/R4/R6/R7: source 37 -> word 1 bit 5
        pulse_src(37, 1);
        repeat (2) @(negedge clk);
        check("R4 irq on source 37", 32'(irq), 1);
        check("R5 fiq without select", 32'(fiq), 0);
        bus_read(10'h014, 32'h20, "R2 R7 pend w1 sticky");
        bus_read(10'h000, 32'd148, "R6 vector source 37");

        // R6 priority: add 70 and 5
        pulse_src(70, 1);
        pulse_src(5, 1);
        bus_read(10'h000, 32'd20, "R6 vector source 5 wins");
        bus_read(10'h018, 32'h40, "R7 pend w2");

        // R3 write-one-to-clear
        bus_write(10'h010, 32'h20);
        bus_read(10'h000, 32'd148, "R3 after clear of 5");
        bus_write(10'h014, 32'h0);
        bus_read(10'h014, 32'h20, "R3 zero write keeps");

        // R4/R6 masking
        bus_write(10'h054, 32'h20);
        bus_read(10'h000, 32'd280, "R6 vector source 70");
        bus_write(10'h058, 32'h40);
        check("R4 irq all masked", 32'(irq), 0);
        bus_read(10'h000, 0, "R6 vector none");
        bus_read(10'h018, 32'h40, "R4 mask keeps pending");

        // R5 select
        bus_write(10'h038, 32'h40);
        check("R5 fiq masked source", 32'(fiq), 0);
        bus_write(10'h058, 32'h0);
        check("R5 fiq unmasked selected", 32'(fiq), 1);
        check("R4 irq unmasked", 32'(irq), 1);

        // R9 storage-only banks
        bus_write(10'h040, 32'hFFFF_FFFF);
        bus_write(10'h048, 32'h0);
        bus_write(10'h028, 32'hFFFF_FFFF);
        check("R9 fiq unaffected", 32'(fiq), 1);
        check("R9 irq unaffected", 32'(irq), 1);
        bus_read(10'h040, 32'hFFFF_FFFF, "R9 enable w0");
        bus_read(10'h028, 0, "R9 fast pend w2");
        bus_read(10'h000, 32'd280, "R9 vector unaffected");

        // R8 scalar words
        bus_write(10'h004, 32'h1234_5677);
        bus_write(10'h008, 32'hA5);
        bus_write(10'h00C, 32'h3C);
        bus_read(10'h004, 32'h1234_5674, "R8 base low bits");
        bus_read(10'h008, 32'hA5, "R8 protect");
        bus_read(10'h00C, 32'h3C, "R8 nmi");

        // R10 unmapped and read-only offsets
        bus_write(10'h01C, 32'hFFFF_FFFF);
        bus_write(10'h000, 32'h55);
        bus_write(10'h200, 32'h1);
        bus_write(10'h056, 32'hFFFF_FFFF);
        bus_read(10'h014, 32'h20, "R10 pend w1 intact");
        bus_read(10'h018, 32'h40, "R10 pend w2 intact");
        bus_read(10'h058, 0, "R10 mask w2 intact");
        bus_read(10'h000, 32'd280, "R10 vector not written");
        bus_read(10'h01C, 0, "R10 read word 3");
        bus_read(10'h3FC, 0, "R10 read top");
        bus_read(10'h060, 0, "R10 read past banks");
        bus_read(10'h005, 0, "R10 read unaligned");

        // R3 same-cycle set and clear: source 10
        @(negedge clk);
        src[10] = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h010; req_wdata = 32'h400;
        @(negedge clk);
        src[10] = 1'b0;
        req_valid = 1'b0; req_write = 1'b0;
        bus_read(10'h010, 32'h400, "R3 source wins over clear");
        bus_read(10'h000, 32'd40, "R6 vector source 10");
        bus_write(10'h010, 32'h400);
        bus_read(10'h010, 0, "R3 clear idle source");
        bus_read(10'h000, 32'd280, "R6 vector back to 70");

        // R6 source 0 vs none; R2 held level
        bus_write(10'h014, 32'hFFFF_FFFF);
        bus_write(10'h018, 32'hFFFF_FFFF);
        check("R4 irq cleared", 32'(irq), 0);
        check("R5 fiq cleared", 32'(fiq), 0);
        pulse_src(0, 3);
        @(negedge clk);
        check("R6 irq source 0", 32'(irq), 1);
        bus_read(10'h000, 0, "R6 vector source 0");
        bus_read(10'h010, 32'h1, "R2 held level sticky");

        finish_run();
    end
endmodule